// File: doc/BRIEF.md
# Frame-Sync Standby and Clock-Rate Monitor

This block watches the transmit and receive frame-sync strobes of each voice channel of a dual-channel converter. Each strobe normally pulses once per 125 µs frame. When both strobes of a channel fall silent for long enough, the block raises that channel's standby flag. A pulse on both strobes brings the channel back out. If only one strobe of a channel stops, the channel is in an undefined state. The block does not enter standby then and raises that channel's error flag instead.

The block also finds the master clock rate after reset. It counts master-clock cycles between two successive pulses on the channel 0 transmit strobe. About 256 cycles means the slow clock (2.048 MHz) and about 512 means the fast clock (4.096 MHz). Once a rate is recognised it stays fixed until the next reset. The silence timeout covers four frames, so it is 1024 cycles on the slow clock and 2048 cycles on the fast one. Until a rate is known, the longer timeout applies.

Top module: `sync_standby_monitor`

## Requirements
- R1: After reset, every standby flag, every error flag, rateValid and rateHigh read 0.
- R2: A pulse is a rising edge of a strobe. If the number of clock cycles between two successive pulses on channel 0 transmit lies within 256±8, rateValid goes to 1 with rateHigh 0. If it lies within 512±8, rateValid goes to 1 with rateHigh 1. After that, both stay fixed until reset, even if the strobe period changes.
- R3: If one strobe of a channel pulses while the other has been silent for at least the timeout, that channel's error flag is set and the channel stays out of standby. The flag clears once both strobes pulse again.
- R4: A channel enters standby once both of its strobes have been silent for the timeout: 1024 cycles when rateValid is 1 and rateHigh is 0, and 2048 cycles when rateHigh is 1.
- R5: Each channel's standby and error state depends only on that channel's strobes. Bit i of standby and syncErr belongs to channel i.
- R6: A channel in standby leaves it only after both of its strobes have pulsed. A pulse on only one strobe keeps it in standby.
- R7: A period that falls in neither window leaves rateValid at 0 and rateHigh at 0.
- R8: While rateValid is 0, the 2048-cycle timeout applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncTx | input | NCH | Transmit frame-sync strobe per channel |
| syncRx | input | NCH | Receive frame-sync strobe per channel |
| standby | output | NCH | Channel is in standby |
| syncErr | output | NCH | Only one strobe of the channel is alive |
| rateValid | output | 1 | Clock rate has been recognised |
| rateHigh | output | 1 | 1 for the fast clock, 0 for the slow clock |

## Verification
The hardest condition to reach is the one-sided failure. One strobe must go quiet past a full timeout while its partner keeps pulsing, and the other channel must stay undisturbed. The bench stops a single receive strobe right after one of its pulses and lets the transmit strobe run on for several thousand cycles, then restores the strobe. Standby entry is probed on both sides of the exact boundary by synchronising to a pulse the bench observes. The same is done under each clock rate and with the rate still unknown, so the timeout length is visible at the ports.

// File: rtl/sync_standby_pkg.sv
package sync_standby_pkg;

  typedef enum logic [1:0] {
    RATE_IDLE    = 2'd0,
    RATE_MEASURE = 2'd1,
    RATE_LOCKED  = 2'd2
  } rateState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rateRestart;   // load period counter with 1
    logic rateCount;     // advance period counter
    logic useLongLimit;  // select the longer silence timeout
  } dpStrobes_t;

endpackage

// File: rtl/sync_silence_counter.sv
module sync_silence_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         quiet
);

  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (count < limit) begin
      count <= count + 1'b1;
    end
  end

  assign quiet = (count >= limit);

endmodule

// File: rtl/sync_standby_dp.sv
module sync_standby_dp
  import sync_standby_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int RATE_LO_CYC = 256,
  parameter int RATE_HI_CYC = 512,
  parameter int RATE_TOL    = 8,
  parameter int TIMEOUT_LO  = 1024,
  parameter int TIMEOUT_HI  = 2048
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] syncTx,
  input  logic [NCH-1:0] syncRx,
  input  dpStrobes_t     strobes,
  output logic [NCH-1:0] riseTx,
  output logic [NCH-1:0] riseRx,
  output logic [NCH-1:0] quietTx,
  output logic [NCH-1:0] quietRx,
  output logic           periodLo,
  output logic           periodHi
);

  localparam int SIL_W = $clog2(TIMEOUT_HI + 1);
  localparam int PER_W = $clog2(RATE_HI_CYC + RATE_TOL + 2);
  localparam logic [PER_W-1:0] LO_MIN = PER_W'(RATE_LO_CYC - RATE_TOL);
  localparam logic [PER_W-1:0] LO_MAX = PER_W'(RATE_LO_CYC + RATE_TOL);
  localparam logic [PER_W-1:0] HI_MIN = PER_W'(RATE_HI_CYC - RATE_TOL);
  localparam logic [PER_W-1:0] HI_MAX = PER_W'(RATE_HI_CYC + RATE_TOL);

  logic [NCH-1:0] txPrev, rxPrev;
  logic [SIL_W-1:0] limitVal;
  logic [PER_W-1:0] perCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPrev <= '0;
      rxPrev <= '0;
    end else begin
      txPrev <= syncTx;
      rxPrev <= syncRx;
    end
  end

  assign riseTx = syncTx & ~txPrev;
  assign riseRx = syncRx & ~rxPrev;

  assign limitVal = strobes.useLongLimit ? SIL_W'(TIMEOUT_HI) : SIL_W'(TIMEOUT_LO);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_silence
    sync_silence_counter #(.W(SIL_W)) u_txSilence (
      .clk   (clk),
      .rstN  (rstN),
      .clear (riseTx[ch]),
      .limit (limitVal),
      .quiet (quietTx[ch])
    );
    sync_silence_counter #(.W(SIL_W)) u_rxSilence (
      .clk   (clk),
      .rstN  (rstN),
      .clear (riseRx[ch]),
      .limit (limitVal),
      .quiet (quietRx[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perCnt <= '0;
    end else if (strobes.rateRestart) begin
      perCnt <= PER_W'(1);
    end else if (strobes.rateCount && (perCnt != '1)) begin
      perCnt <= perCnt + 1'b1;
    end
  end

  assign periodLo = (perCnt >= LO_MIN) && (perCnt <= LO_MAX);
  assign periodHi = (perCnt >= HI_MIN) && (perCnt <= HI_MAX);

endmodule

// File: rtl/sync_standby_ctl.sv
module sync_standby_ctl
  import sync_standby_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] riseTx,
  input  logic [NCH-1:0] riseRx,
  input  logic [NCH-1:0] quietTx,
  input  logic [NCH-1:0] quietRx,
  input  logic           periodLo,
  input  logic           periodHi,
  output dpStrobes_t     strobes,
  output logic [NCH-1:0] standby,
  output logic [NCH-1:0] syncErr,
  output logic           rateValid,
  output logic           rateHigh
);

  rateState_t rateState, rateStateNext;
  logic rateValidNext, rateHighNext;

  // rate recognition on channel 0 transmit strobe
  always_comb begin
    rateStateNext       = rateState;
    rateValidNext       = rateValid;
    rateHighNext        = rateHigh;
    strobes.rateRestart = 1'b0;
    strobes.rateCount   = 1'b0;
    unique case (rateState)
      RATE_IDLE: begin
        if (riseTx[0]) begin
          strobes.rateRestart = 1'b1;
          rateStateNext       = RATE_MEASURE;
        end
      end
      RATE_MEASURE: begin
        strobes.rateCount = 1'b1;
        if (riseTx[0]) begin
          if (periodLo) begin
            rateStateNext = RATE_LOCKED;
            rateValidNext = 1'b1;
            rateHighNext  = 1'b0;
          end else if (periodHi) begin
            rateStateNext = RATE_LOCKED;
            rateValidNext = 1'b1;
            rateHighNext  = 1'b1;
          end else begin
            strobes.rateRestart = 1'b1;
          end
        end
      end
      default: begin
        rateStateNext = RATE_LOCKED;
      end
    endcase
  end

  assign strobes.useLongLimit = !(rateValid && !rateHigh);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateState <= RATE_IDLE;
      rateValid <= 1'b0;
      rateHigh  <= 1'b0;
    end else begin
      rateState <= rateStateNext;
      rateValid <= rateValidNext;
      rateHigh  <= rateHighNext;
    end
  end

  // per-channel standby and error decisions
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic seenTx, seenRx;
    logic stbyNext, errNext, exitNow;

    always_comb begin
      exitNow = (seenTx | riseTx[ch]) & (seenRx | riseRx[ch]);
      if (standby[ch]) begin
        stbyNext = !exitNow;
      end else begin
        stbyNext = quietTx[ch] & quietRx[ch] & !riseTx[ch] & !riseRx[ch];
      end

      if (stbyNext) begin
        errNext = 1'b0;
      end else if ((riseTx[ch] && quietRx[ch]) || (riseRx[ch] && quietTx[ch])) begin
        errNext = 1'b1;
      end else if (!quietTx[ch] && !quietRx[ch]) begin
        errNext = 1'b0;
      end else begin
        errNext = syncErr[ch];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        standby[ch] <= 1'b0;
        syncErr[ch] <= 1'b0;
        seenTx      <= 1'b0;
        seenRx      <= 1'b0;
      end else begin
        standby[ch] <= stbyNext;
        syncErr[ch] <= errNext;
        seenTx      <= standby[ch] & (seenTx | riseTx[ch]);
        seenRx      <= standby[ch] & (seenRx | riseRx[ch]);
      end
    end
  end

endmodule

// File: rtl/sync_standby_monitor.sv
module sync_standby_monitor
  import sync_standby_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int RATE_LO_CYC = 256,
  parameter int RATE_HI_CYC = 512,
  parameter int RATE_TOL    = 8,
  parameter int TIMEOUT_LO  = 1024,
  parameter int TIMEOUT_HI  = 2048
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] syncTx,
  input  logic [NCH-1:0] syncRx,
  output logic [NCH-1:0] standby,
  output logic [NCH-1:0] syncErr,
  output logic           rateValid,
  output logic           rateHigh
);

  dpStrobes_t strobes;
  logic [NCH-1:0] riseTx, riseRx, quietTx, quietRx;
  logic periodLo, periodHi;

  sync_standby_dp #(
    .NCH(NCH), .RATE_LO_CYC(RATE_LO_CYC), .RATE_HI_CYC(RATE_HI_CYC),
    .RATE_TOL(RATE_TOL), .TIMEOUT_LO(TIMEOUT_LO), .TIMEOUT_HI(TIMEOUT_HI)
  ) u_dp (
    .clk(clk), .rstN(rstN), .syncTx(syncTx), .syncRx(syncRx),
    .strobes(strobes), .riseTx(riseTx), .riseRx(riseRx),
    .quietTx(quietTx), .quietRx(quietRx),
    .periodLo(periodLo), .periodHi(periodHi)
  );

  sync_standby_ctl #(.NCH(NCH)) u_ctl (
    .clk(clk), .rstN(rstN), .riseTx(riseTx), .riseRx(riseRx),
    .quietTx(quietTx), .quietRx(quietRx),
    .periodLo(periodLo), .periodHi(periodHi), .strobes(strobes),
    .standby(standby), .syncErr(syncErr),
    .rateValid(rateValid), .rateHigh(rateHigh)
  );

endmodule

// File: rtl/sync_standby_checker.sv
module sync_standby_checker #(
  parameter int NCH        = 2,
  parameter int TIMEOUT_LO = 1024
) (
  input logic           clk,
  input logic           rstN,
  input logic [NCH-1:0] syncTx,
  input logic [NCH-1:0] syncRx,
  input logic [NCH-1:0] standby,
  input logic [NCH-1:0] syncErr,
  input logic           rateValid,
  input logic           rateHigh
);

  localparam int CW = $clog2(TIMEOUT_LO + 2);
  localparam logic [CW-1:0] SAT = CW'(TIMEOUT_LO + 1);

  logic [NCH-1:0] txSeen, rxSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSeen <= '0;
      rxSeen <= '0;
    end else begin
      txSeen <= syncTx;
      rxSeen <= syncRx;
    end
  end

  AST_HIGH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rateHigh |-> rateValid); // R7
  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    rateValid |=> rateValid); // R2
  AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    rateValid |=> $stable(rateHigh)); // R2

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    logic [CW-1:0] silCnt;
    logic anyRise;
    assign anyRise = (syncTx[ch] & ~txSeen[ch]) | (syncRx[ch] & ~rxSeen[ch]);

    always_ff @(posedge clk) begin
      if (!rstN) silCnt <= '0;
      else if (anyRise) silCnt <= '0;
      else if (silCnt != SAT) silCnt <= silCnt + 1'b1;
    end

    AST_STBY_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
      !(standby[ch] && syncErr[ch])); // R3
    AST_STBY_AFTER_SILENCE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(standby[ch]) |-> (silCnt > CW'(TIMEOUT_LO))); // R4
    AST_EXIT_ON_PULSE: assert property (@(posedge clk) disable iff (!rstN)
      $fell(standby[ch]) |-> ($past(syncTx[ch]) || $past(syncRx[ch]))); // R6
  end

endmodule

bind sync_standby_monitor sync_standby_checker #(
  .NCH(NCH), .TIMEOUT_LO(TIMEOUT_LO)
) u_checker (
  .clk(clk), .rstN(rstN), .syncTx(syncTx), .syncRx(syncRx),
  .standby(standby), .syncErr(syncErr),
  .rateValid(rateValid), .rateHigh(rateHigh)
);

// File: tb/sync_standby_monitor_bench.sv
module sync_standby_monitor_bench;

  localparam int NCH = 2;

  typedef struct {
    string tag;
    int    field;   // 0 standby, 1 syncErr, 2 rateValid, 3 rateHigh
    int    expVal;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0] syncTx = '0;
  logic [NCH-1:0] syncRx = '0;
  logic [NCH-1:0] standby, syncErr;
  logic rateValid, rateHigh;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  item_t q[$];
  event sampleEv;

  int period = 256;
  int cyc = 0;
  bit enTx[NCH];
  bit enRx[NCH];
  int phTx[NCH] = '{0, 40};
  int phRx[NCH] = '{0, 100};

  sync_standby_monitor u_sync_standby_monitor (
    .clk(clk), .rstN(rstN), .syncTx(syncTx), .syncRx(syncRx),
    .standby(standby), .syncErr(syncErr),
    .rateValid(rateValid), .rateHigh(rateHigh)
  );

  always #5 clk = ~clk;

  // strobe generator: one-cycle pulses, changed at falling edges
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      for (int i = 0; i < NCH; i++) begin
        syncTx[i] = enTx[i] && ((cyc % period) == phTx[i]);
        syncRx[i] = enRx[i] && ((cyc % period) == phRx[i]);
      end
    end
  end

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(sampleEv);
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        case (it.field)
          0: act = int'(standby);
          1: act = int'(syncErr);
          2: act = int'(rateValid);
          default: act = int'(rateHigh);
        endcase
        checks++;
        if (act != it.expVal) begin
          errors++;
          $display("FAIL %s field %0d: actual %0d expected %0d", it.tag, it.field, act, it.expVal);
        end
      end
    end
  end

  task automatic expectOut(string tag, int field, int expVal);
    item_t it;
    it.tag = tag; it.field = field; it.expVal = expVal;
    q.push_back(it);
    -> sampleEv;
    #1;
  endtask

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(int newPeriod);
    rstN = 1'b0;
    period = newPeriod;
    for (int i = 0; i < NCH; i++) begin enTx[i] = 1; enRx[i] = 1; end
    ticks(3);
    rstN = 1'b1;
  endtask

  // wait for a receive pulse on channel ch, then silence both strobes
  task automatic stopChannel(int ch);
    do @(posedge clk); while (syncRx[ch] !== 1'b1);
    enTx[ch] = 0;
    enRx[ch] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    doReset(256);
    expectOut("R1 standby", 0, 0);
    expectOut("R1 syncErr", 1, 0);
    expectOut("R1 rateValid", 2, 0);
    expectOut("R1 rateHigh", 3, 0);

    // R2 slow clock recognised
    ticks(800);
    expectOut("R2 slow valid", 2, 1);
    expectOut("R2 slow rate", 3, 0);

    // R4 and R5: channel 0 silent, short timeout
    stopChannel(0);
    ticks(1023);
    expectOut("R4 before short timeout", 0, 0);
    ticks(5);
    expectOut("R4 after short timeout", 0, 1);
    expectOut("R5 channel 1 unaffected err", 1, 0);

    // R6: one strobe alone does not wake the channel
    enTx[0] = 1;
    ticks(700);
    expectOut("R6 single strobe keeps standby", 0, 1);
    expectOut("R6 no error in standby", 1, 0);
    enRx[0] = 1;
    ticks(300);
    expectOut("R6 both strobes wake", 0, 0);

    // R3: channel 1 receive strobe stops alone
    do @(posedge clk); while (syncRx[1] !== 1'b1);
    enRx[1] = 0;
    ticks(1400);
    expectOut("R3 error raised", 1, 2);
    ticks(2500);
    expectOut("R3 no standby", 0, 0);
    expectOut("R3 error held", 1, 2);
    enRx[1] = 1;
    ticks(400);
    expectOut("R3 error cleared", 1, 0);

    // R2 fast clock, R4 long timeout
    doReset(512);
    ticks(1600);
    expectOut("R2 fast valid", 2, 1);
    expectOut("R2 fast rate", 3, 1);
    stopChannel(1);
    ticks(2045);
    expectOut("R4 before long timeout", 0, 0);
    ticks(8);
    expectOut("R4 R5 after long timeout", 0, 2);

    // R7 and R8: period out of range
    doReset(384);
    ticks(1600);
    expectOut("R7 invalid rate", 2, 0);
    expectOut("R7 rateHigh low", 3, 0);
    stopChannel(0);
    ticks(2045);
    expectOut("R8 long timeout before", 0, 0);
    ticks(8);
    expectOut("R8 long timeout after", 0, 1);

    // R2 tolerance and lock
    doReset(262);
    ticks(1000);
    expectOut("R2 tolerance valid", 2, 1);
    expectOut("R2 tolerance slow", 3, 0);
    period = 512;
    ticks(1600);
    expectOut("R2 locked valid", 2, 1);
    expectOut("R2 locked rate", 3, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule